// File: doc/BRIEF.md
# Eight-Function Shift and Rotate Register

This block is a parameterised register whose next value each clock cycle comes from one of eight operations, picked by a 3-bit function select. It can shift or rotate in either direction, hold its value, take a new value from a parallel input, invert every bit, or set every bit to one. The two shift directions take their incoming bit from separate serial inputs.

Bit ordering runs from the most significant bit (the leftmost position) down to bit 0 (the rightmost). "Left" means toward the MSB. All operations take effect on the rising clock edge. An active-low synchronous reset clears the register and wins over any select value. Control logic elsewhere uses the block as a general working register or as a serial converter.

Top module: `multi_func_reg`

## Requirements
- R1: Select 3'b000 shifts left by one. Every bit moves one place toward the MSB, and `shl_in_i` enters bit 0.
- R2: Select 3'b001 rotates left by one. The old MSB wraps into bit 0.
- R3: Select 3'b010 shifts right by one. Every bit moves one place toward bit 0, and `shr_in_i` enters the MSB.
- R4: Select 3'b011 rotates right by one. The old bit 0 wraps into the MSB.
- R5: Select 3'b100 keeps the register unchanged. The serial and parallel inputs have no effect.
- R6: Select 3'b101 loads `par_i` into the register.
- R7: Select 3'b110 replaces the register with its bitwise complement.
- R8: Select 3'b111 sets every bit to 1.
- R9: When `rst_ni` is low at a rising edge, the register becomes all zeros whatever the select.
- R10: Exactly one operation is applied per clock. Starting from 4'b0101, with `par_i`=4'b0011, `shl_in_i`=1 and `shr_in_i`=0, applying the selects 000 through 111 in order gives 1011, 0111, 0011, 1001, 1001, 0011, 1100, 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous reset, active low |
| sel_i | input | 3 | Function select |
| shl_in_i | input | 1 | Serial bit that enters bit 0 on a left shift |
| shr_in_i | input | 1 | Serial bit that enters the MSB on a right shift |
| par_i | input | WIDTH | Parallel load data |
| q_o | output | WIDTH | Register contents |

## Verification
The bound checker compares each cycle's register value against the previous cycle's value, select and inputs, for all eight operations. It also checks that reset forces zero. This covers R1 through R9 on every cycle of any run. The chained sequence in R10 depends on the order and effect of consecutive operations, so only the bench's directed scenario shows it. The bench also runs a long random mix, including resets asserted under every select, and compares it against an independent model.

// File: rtl/multi_func_reg_pkg.sv
package multi_func_reg_pkg;
  typedef enum logic [2:0] {
    OP_SHL  = 3'b000,
    OP_ROL  = 3'b001,
    OP_SHR  = 3'b010,
    OP_ROR  = 3'b011,
    OP_HOLD = 3'b100,
    OP_LOAD = 3'b101,
    OP_INV  = 3'b110,
    OP_ONES = 3'b111
  } op_e;
endpackage

// File: rtl/mfr_edge_fill.sv
// Picks the bit entering the vacated end for shifts and rotates.
module mfr_edge_fill
  import multi_func_reg_pkg::*;
(
  input  op_e  op_i,
  input  logic shl_in_i,
  input  logic shr_in_i,
  input  logic q_msb_i,
  input  logic q_lsb_i,
  output logic fill_lsb_o,
  output logic fill_msb_o
);
  always_comb begin
    fill_lsb_o = (op_i == OP_ROL) ? q_msb_i : shl_in_i;
    fill_msb_o = (op_i == OP_ROR) ? q_lsb_i : shr_in_i;
  end
endmodule

// File: rtl/mfr_next_state.sv
module mfr_next_state
  import multi_func_reg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  op_e              op_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             fill_lsb_i,
  input  logic             fill_msb_i,
  output logic [WIDTH-1:0] d_o
);
  localparam int MSB = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_right;  // value moving left into bit i
    logic from_left;   // value moving right into bit i

    if (i == 0) begin : g_lo
      assign from_right = fill_lsb_i;
    end else begin : g_lo_n
      assign from_right = q_i[i-1];
    end

    if (i == MSB) begin : g_hi
      assign from_left = fill_msb_i;
    end else begin : g_hi_n
      assign from_left = q_i[i+1];
    end

    always_comb begin
      unique case (op_i)
        OP_SHL, OP_ROL: d_o[i] = from_right;
        OP_SHR, OP_ROR: d_o[i] = from_left;
        OP_HOLD:        d_o[i] = q_i[i];
        OP_LOAD:        d_o[i] = par_i[i];
        OP_INV:         d_o[i] = ~q_i[i];
        OP_ONES:        d_o[i] = 1'b1;
        default:        d_o[i] = q_i[i];
      endcase
    end
  end
endmodule

// File: rtl/mfr_state.sv
module mfr_state #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/multi_func_reg.sv
module multi_func_reg
  import multi_func_reg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       sel_i,
  input  logic             shl_in_i,
  input  logic             shr_in_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int MSB = WIDTH - 1;

  op_e              op;
  logic             fill_lsb;
  logic             fill_msb;
  logic [WIDTH-1:0] d;

  assign op = op_e'(sel_i);

  mfr_edge_fill i_fill (
    .op_i      (op),
    .shl_in_i  (shl_in_i),
    .shr_in_i  (shr_in_i),
    .q_msb_i   (q_o[MSB]),
    .q_lsb_i   (q_o[0]),
    .fill_lsb_o(fill_lsb),
    .fill_msb_o(fill_msb)
  );

  mfr_next_state #(.WIDTH(WIDTH)) i_next (
    .op_i      (op),
    .q_i       (q_o),
    .par_i     (par_i),
    .fill_lsb_i(fill_lsb),
    .fill_msb_i(fill_msb),
    .d_o       (d)
  );

  mfr_state #(.WIDTH(WIDTH)) i_state (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (d),
    .q_o   (q_o)
  );
endmodule

// File: rtl/multi_func_reg_chk.sv
module multi_func_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       sel_i,
  input logic             shl_in_i,
  input logic             shr_in_i,
  input logic [WIDTH-1:0] par_i,
  input logic [WIDTH-1:0] q_o
);
  localparam int MSB = WIDTH - 1;

  AST_SHIFT_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b000 |=> q_o == {$past(q_o[MSB-1:0]), $past(shl_in_i)}); // R1
  AST_ROTATE_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b001 |=> q_o == {$past(q_o[MSB-1:0]), $past(q_o[MSB])}); // R2
  AST_SHIFT_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b010 |=> q_o == {$past(shr_in_i), $past(q_o[MSB:1])}); // R3
  AST_ROTATE_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b011 |=> q_o == {$past(q_o[0]), $past(q_o[MSB:1])}); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b100 |=> $stable(q_o)); // R5
  AST_LOAD_PAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b101 |=> q_o == $past(par_i)); // R6
  AST_INVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b110 |=> q_o == ~$past(q_o)); // R7
  AST_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'b111 |=> q_o == '1); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    rst_ni == 1'b0 |=> q_o == '0); // R9
endmodule

bind multi_func_reg multi_func_reg_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .shl_in_i(shl_in_i),
  .shr_in_i(shr_in_i),
  .par_i   (par_i),
  .q_o     (q_o)
);

// File: tb/test_multi_func_reg.sv
`timescale 1ns/1ps
module test_multi_func_reg;
  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [2:0]   sel_i;
  logic         shl_in_i;
  logic         shr_in_i;
  logic [W-1:0] par_i;
  logic [W-1:0] q_o;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] model_q;

  always #2.5 clk_i = ~clk_i;

  multi_func_reg #(.WIDTH(W)) i_multi_func_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .shl_in_i(shl_in_i),
    .shr_in_i(shr_in_i), .par_i(par_i), .q_o(q_o)
  );

  function automatic logic [W-1:0] ref_next(logic [W-1:0] q, logic [2:0] s,
                                            logic l, logic r, logic [W-1:0] d);
    case (s)
      3'd0: return {q[W-2:0], l};
      3'd1: return {q[W-2:0], q[W-1]};
      3'd2: return {r, q[W-1:1]};
      3'd3: return {q[0], q[W-1:1]};
      3'd4: return q;
      3'd5: return d;
      3'd6: return ~q;
      default: return '1;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] s);
    case (s)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] exp);
    checks++;
    if (q_o !== exp) begin
      failures++;
      $display("FAIL %s: q_o=%b expected=%b", req, q_o, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic step(logic rn, logic [2:0] s, logic l, logic r, logic [W-1:0] d);
    rst_ni = rn; sel_i = s; shl_in_i = l; shr_in_i = r; par_i = d;
    model_q = rn ? ref_next(model_q, s, l, r, d) : '0;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  logic [W-1:0] chain_exp [8];

  initial begin
    void'($urandom(32'd20240611));
    chain_exp[0] = 4'b1011; chain_exp[1] = 4'b0111;
    chain_exp[2] = 4'b0011; chain_exp[3] = 4'b1001;
    chain_exp[4] = 4'b1001; chain_exp[5] = 4'b0011;
    chain_exp[6] = 4'b1100; chain_exp[7] = 4'b1111;
    model_q = '0;
    rst_ni = 1'b0; sel_i = 3'd7; shl_in_i = 1'b1; shr_in_i = 1'b1; par_i = '1;
    @(negedge clk_i);
    step(1'b0, 3'd7, 1'b1, 1'b1, 4'hF);
    check("R9", 4'b0000);

    // R10 chained sequence
    step(1'b1, 3'd5, 1'b0, 1'b0, 4'b0101);
    check("R6", 4'b0101);
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 3'(k), 1'b1, 1'b0, 4'b0011);
      check("R10", chain_exp[k]);
    end

    // R5 hold ignores toggling serial and parallel inputs
    step(1'b1, 3'd5, 1'b0, 1'b0, 4'b1010);
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 3'd4, k[0], ~k[0], 4'(k * 5));
      check("R5", 4'b1010);
    end

    // R2/R4 full-circle rotations return to start
    for (int k = 0; k < W; k++) step(1'b1, 3'd1, 1'b0, 1'b1, 4'h0);
    check("R2", 4'b1010);
    for (int k = 0; k < W; k++) step(1'b1, 3'd3, 1'b1, 1'b0, 4'h0);
    check("R4", 4'b1010);

    // R1/R3 fill the register entirely from the serial inputs
    for (int k = 0; k < W; k++) step(1'b1, 3'd0, 1'b1, 1'b0, 4'h0);
    check("R1", 4'b1111);
    for (int k = 0; k < W; k++) step(1'b1, 3'd2, 1'b1, 1'b0, 4'h0);
    check("R3", 4'b0000);

    // R9 reset overrides each select value
    for (int s = 0; s < 8; s++) begin
      step(1'b1, 3'd7, 1'b0, 1'b0, 4'h0);
      step(1'b0, 3'(s), 1'b1, 1'b1, 4'hF);
      check("R9", 4'b0000);
    end

    // random mix checked against the model
    for (int n = 0; n < 2000; n++) begin
      logic [2:0] s;
      logic rn;
      s  = 3'($urandom_range(0, 7));
      rn = ($urandom_range(0, 31) != 0);
      step(rn, s, 1'($urandom), 1'($urandom), W'($urandom));
      check(rn ? req_of(s) : "R9", model_q);
    end
    finish_run();
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: q_o=%b expected=completion", q_o);
    finish_run();
  end
endmodule